// File: doc/BRIEF.md
# Byte ADD executor

This block carries out the two's-complement byte addition instruction of a small 8-bit register-file controller. It accepts the instruction as a stream of bytes, recognises five operand forms from the leading opcode byte, gathers both operands through a single register-file port, writes the sum back to the destination register and updates six condition flags. The source operand is only ever read.

Operands come from one of four places. A 4-bit working-register index is turned into a full register address by OR-ing it onto a register-pointer input. A full 8-bit register address can appear directly in the instruction. A register can hold the address of the real operand (indirect). An immediate byte can sit in the instruction itself. The register file is outside the block. It is reached through an address output whose read data returns in the same cycle, and a write strobe that takes effect on the clock edge. Only one address is presented per cycle. The last cycle is a read-modify-write of the destination.

Every instruction has a fixed length in cycles, counted from the cycle that takes the opcode. A one-cycle `done` pulse marks the final cycle. An unknown opcode is consumed and flagged, and it changes nothing.

Top module: `byte_add_exec`

## Requirements
- R1: The value written to the destination register is destination plus source modulo 256. The only register write of an instruction happens in its final cycle, and no other register is modified.
- R2: After an instruction, `fl_c` equals the carry out of bit 7 of the addition.
- R3: After an instruction, `fl_z` is 1 exactly when the 8-bit result is zero, and `fl_s` equals bit 7 of the result.
- R4: After an instruction, `fl_v` is 1 exactly when both operands have equal bit 7 and the result's bit 7 differs from it.
- R5: After an instruction, `fl_d` is 0 and `fl_h` equals the carry from bit 3 into bit 4.
- R6: Opcode 02h adds working register to working register. Its second byte holds the destination index in bits 7:4 and the source index in bits 3:0. A working index i addresses register `rp | i`. The instruction takes 4 cycles.
- R7: Opcode 03h has the same byte layout as 02h. The source working register holds the address of the operand. The instruction takes 4 cycles.
- R8: Opcodes 04h (direct source) and 05h (source register holds the operand address) are 3 bytes long. The second byte is the source address and the third byte is the destination address. Each takes 6 cycles.
- R9: Opcode 06h is 3 bytes long. The second byte is the destination address and the third is the immediate operand. It takes 6 cycles.
- R10: `done` is high for exactly one cycle per instruction, in the write cycle. The flags change only on the clock edge that ends that cycle.
- R11: `ib_take` is high only while `ib_valid` is high and the block wants a byte. While an operand byte is missing, the block holds, and the instruction grows by one cycle for each missing cycle.
- R12: An idle-state byte outside 02h..06h is taken with `illegal` high for that one cycle. It causes no register write, no `done` and no flag change.
- R13: In reset and directly after it, `done`, `illegal`, `rf_we`, `ib_take` (with no byte offered) and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rp | input | W | Register pointer; working index i maps to `rp \| i` |
| ib_valid | input | 1 | An instruction byte is offered |
| ib_data | input | W | Offered instruction byte |
| ib_take | output | 1 | The offered byte is consumed this cycle |
| rf_addr | output | W | Register-file address for this cycle |
| rf_rdata | input | W | Contents of `rf_addr`, same cycle |
| rf_we | output | 1 | Write `rf_wdata` to `rf_addr` at the clock edge |
| rf_wdata | output | W | Sum to be written |
| done | output | 1 | Final cycle of an instruction |
| illegal | output | 1 | Unknown opcode consumed this cycle |
| fl_c | output | 1 | Carry flag |
| fl_z | output | 1 | Zero flag |
| fl_s | output | 1 | Sign flag |
| fl_v | output | 1 | Overflow flag |
| fl_d | output | 1 | Decimal-adjust flag, cleared by every add |
| fl_h | output | 1 | Half-carry flag |

## Verification
The properties assume that `rp` stays constant from the opcode cycle to `done`. They also assume that `rf_rdata` always shows the register named by `rf_addr` in the same cycle, with a write visible from the next cycle. The bench meets both assumptions. Its register file is an array read combinationally through `rf_addr` and written only at the clock edge. It changes `rp` and preloads registers only while the block is idle, and it never edits a register while an instruction is in flight. Missing bytes are produced by inserting gap cycles into the stream, and opcodes are drawn from both the legal and the unknown ranges.

// File: rtl/byte_add_exec.sv
`timescale 1ns/1ps
module byte_add_exec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rp,
  input  logic         ib_valid,
  input  logic [W-1:0] ib_data,
  output logic         ib_take,
  output logic [W-1:0] rf_addr,
  input  logic [W-1:0] rf_rdata,
  output logic         rf_we,
  output logic [W-1:0] rf_wdata,
  output logic         done,
  output logic         illegal,
  output logic         fl_c,
  output logic         fl_z,
  output logic         fl_s,
  output logic         fl_v,
  output logic         fl_d,
  output logic         fl_h
);
  localparam int NW = W / 2;
  localparam logic [W-1:0] OP_LO = W'(2);
  localparam logic [W-1:0] OP_HI = W'(6);
  localparam logic [2:0] M_RR = 3'd2, M_RI = 3'd3, M_GG = 3'd4, M_GI = 3'd5, M_IM = 3'd6;

  logic         busy;
  logic [2:0]   cyc, mode;
  logic [W-1:0] dst, src;

  wire op_ok    = (ib_data >= OP_LO) && (ib_data <= OP_HI);
  wire short_op = (mode == M_RR) || (mode == M_RI);
  wire [2:0] last = short_op ? 3'd3 : 3'd5;
  wire fetch    = busy && ((cyc == 3'd1) || (cyc == 3'd2 && !short_op));
  wire stall    = fetch && !ib_valid;
  wire exec     = busy && (cyc == last);

  wire [W-1:0] lo_idx = rp | {{(W-NW){1'b0}}, ib_data[NW-1:0]};
  wire [W-1:0] hi_idx = rp | {{(W-NW){1'b0}}, ib_data[W-1:NW]};

  wire [W:0]  sum  = {1'b0, rf_rdata} + {1'b0, src};
  wire [NW:0] nsum = {1'b0, rf_rdata[NW-1:0]} + {1'b0, src[NW-1:0]};

  assign ib_take  = ib_valid && (!busy || fetch);
  assign illegal  = !busy && ib_valid && !op_ok;
  assign done     = exec;
  assign rf_we    = exec;
  assign rf_wdata = sum[W-1:0];

  always_comb begin
    rf_addr = dst;
    if (busy && cyc == 3'd1) begin
      case (mode)
        M_RR, M_RI: rf_addr = lo_idx;
        M_GG, M_GI: rf_addr = ib_data;
        default:    rf_addr = dst;
      endcase
    end else if (busy && cyc == 3'd2 && (mode == M_RI || mode == M_GI)) begin
      rf_addr = src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cyc  <= 3'd0;
      mode <= 3'd0;
      dst  <= '0;
      src  <= '0;
    end else if (!busy) begin
      cyc <= 3'd1;
      if (ib_valid && op_ok) begin
        busy <= 1'b1;
        mode <= ib_data[2:0];
      end
    end else if (!stall) begin
      cyc <= cyc + 3'd1;
      if (exec) busy <= 1'b0;
      if (cyc == 3'd1) begin
        case (mode)
          M_RR, M_RI: begin dst <= hi_idx; src <= rf_rdata; end
          M_GG, M_GI: src <= rf_rdata;
          M_IM:       dst <= ib_data;
          default:    ;
        endcase
      end else if (cyc == 3'd2) begin
        case (mode)
          M_RI:       src <= rf_rdata;
          M_GG:       dst <= ib_data;
          M_GI:       begin dst <= ib_data; src <= rf_rdata; end
          M_IM:       src <= ib_data;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {fl_c, fl_z, fl_s, fl_v, fl_d, fl_h} <= 6'b0;
    end else if (exec) begin
      fl_c <= sum[W];
      fl_z <= (sum[W-1:0] == '0);
      fl_s <= sum[W-1];
      fl_v <= (rf_rdata[W-1] == src[W-1]) && (sum[W-1] != rf_rdata[W-1]);
      fl_d <= 1'b0;
      fl_h <= nsum[NW];
    end
  end
endmodule

// File: rtl/byte_add_exec_chk.sv
`timescale 1ns/1ps
module byte_add_exec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ib_valid,
  input logic         ib_take,
  input logic         rf_we,
  input logic [W-1:0] rf_wdata,
  input logic         done,
  input logic         illegal,
  input logic         fl_c,
  input logic         fl_z,
  input logic         fl_s,
  input logic         fl_v,
  input logic         fl_d,
  input logic         fl_h
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable({fl_c, fl_z, fl_s, fl_v, fl_d, fl_h}));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (fl_z == ($past(rf_wdata) == '0)));

  // R3
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (fl_s == $past(rf_wdata[W-1])));

  // R5
  d_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !fl_d);

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (ib_take && !rf_we && !done));

  // R11
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_take |-> ib_valid);
endmodule

bind byte_add_exec byte_add_exec_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ib_valid(ib_valid), .ib_take(ib_take),
  .rf_we(rf_we), .rf_wdata(rf_wdata), .done(done), .illegal(illegal),
  .fl_c(fl_c), .fl_z(fl_z), .fl_s(fl_s), .fl_v(fl_v), .fl_d(fl_d), .fl_h(fl_h)
);

// File: tb/sim_byte_add_exec.sv
`timescale 1ns/1ps
module sim_byte_add_exec;
  logic       clk = 0, rst_n = 0, ib_valid = 0;
  logic [7:0] rp = 0, ib_data = 0;
  logic       ib_take, rf_we, done, illegal;
  logic [7:0] rf_addr, rf_rdata, rf_wdata;
  logic       fl_c, fl_z, fl_s, fl_v, fl_d, fl_h;
  wire  [5:0] fl = {fl_c, fl_z, fl_s, fl_v, fl_d, fl_h};

  byte_add_exec #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rp(rp), .ib_valid(ib_valid), .ib_data(ib_data),
    .ib_take(ib_take), .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .done(done), .illegal(illegal),
    .fl_c(fl_c), .fl_z(fl_z), .fl_s(fl_s), .fl_v(fl_v), .fl_d(fl_d), .fl_h(fl_h));

  always #5 clk = ~clk;

  logic [7:0] mem  [256];
  logic [7:0] mref [256];
  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  int checks = 0, errors = 0, gcyc = 0, op_cyc = 0, d_len = 0, ill_seen = 0;
  logic [8:0] q[$];

  bit         m_busy = 0;
  int         m_need = 0, m_left = 0;
  logic [7:0] m_op, m_rp;
  logic [7:0] m_b[$];
  logic [5:0] m_fl = 6'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b); q.push_back({1'b1, b}); endtask
  task automatic gap(); q.push_back(9'h0); endtask
  task automatic setreg(logic [7:0] a, logic [7:0] v); mem[a] = v; mref[a] = v; endtask

  task automatic step();
    bit v, e_take, e_ill, e_done, pop;
    logic [7:0] b, da, sv, dv, r8;
    int r;
    @(negedge clk);
    gcyc++;
    v = 0; b = 0;
    if (q.size() > 0) begin v = q[0][8]; b = q[0][7:0]; end
    ib_valid = v; ib_data = b;
    #1;
    chk("R2", "fl_c", fl_c, m_fl[5]);
    chk("R3", "fl_z", fl_z, m_fl[4]);
    chk("R3", "fl_s", fl_s, m_fl[3]);
    chk("R4", "fl_v", fl_v, m_fl[2]);
    chk("R5", "fl_d", fl_d, m_fl[1]);
    chk("R5", "fl_h", fl_h, m_fl[0]);
    e_take = 0; e_ill = 0; e_done = 0; da = 0; r8 = 0;
    pop = (q.size() > 0) && !v;
    if (!m_busy) begin
      if (v) begin
        e_take = 1; pop = 1;
        if (b >= 8'd2 && b <= 8'd6) begin
          m_busy = 1; m_op = b; m_rp = rp; m_b.delete(); op_cyc = gcyc;
          m_need = (b <= 8'd3) ? 1 : 2;
          m_left = (b <= 8'd3) ? 3 : 5;
        end else e_ill = 1;
      end
    end else if (!(m_need > 0 && !v)) begin
      if (m_need > 0) begin e_take = 1; pop = 1; m_b.push_back(b); m_need--; end
      m_left--;
      if (m_left == 0) begin
        case (m_op)
          8'd2: begin da = m_rp | {4'h0, m_b[0][7:4]}; sv = mref[m_rp | {4'h0, m_b[0][3:0]}]; end
          8'd3: begin da = m_rp | {4'h0, m_b[0][7:4]}; sv = mref[mref[m_rp | {4'h0, m_b[0][3:0]}]]; end
          8'd4: begin da = m_b[1]; sv = mref[m_b[0]]; end
          8'd5: begin da = m_b[1]; sv = mref[mref[m_b[0]]]; end
          default: begin da = m_b[0]; sv = m_b[1]; end
        endcase
        dv = mref[da];
        r = int'(dv) + int'(sv);
        r8 = r[7:0];
        m_fl[5] = (r > 255);
        m_fl[4] = (r8 == 0);
        m_fl[3] = r8[7];
        m_fl[2] = (dv[7] == sv[7]) && (r8[7] != dv[7]);
        m_fl[1] = 0;
        m_fl[0] = ((int'(dv[3:0]) + int'(sv[3:0])) > 15);
        mref[da] = r8;
        e_done = 1; m_busy = 0;
      end
    end
    chk("R11", "ib_take", ib_take, e_take);
    chk("R12", "illegal", illegal, e_ill);
    chk("R10", "done", done, e_done);
    chk("R1", "rf_we", rf_we, e_done);
    if (e_done) begin
      chk("R1", "rf_addr", rf_addr, da);
      chk("R1", "rf_wdata", rf_wdata, r8);
    end
    if (done) d_len = gcyc - op_cyc + 1;
    if (illegal) ill_seen++;
    if (pop) q.pop_front();
  endtask

  task automatic run();
    int guard = 0;
    while ((q.size() > 0 || m_busy) && guard < 5000) begin step(); guard++; end
    if (guard >= 5000) chk("R11", "run stuck", 1, 0);
    step();
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; mref[i] = 8'h00; end
    repeat (3) @(negedge clk);
    #1;
    chk("R13", "done in reset", done, 0);
    chk("R13", "rf_we in reset", rf_we, 0);
    chk("R13", "flags in reset", fl, 0);
    rst_n = 1;
    #1;
    chk("R13", "ib_take idle", ib_take, 0);
    chk("R13", "illegal idle", illegal, 0);
    chk("R13", "flags after reset", fl, 0);

    rp = 8'hC0;
    setreg(8'hC1, 8'h12); setreg(8'hC2, 8'h03);
    setreg(8'h01, 8'h21); setreg(8'h02, 8'h03); setreg(8'h03, 8'h0A);

    put(8'h02); put(8'h12); run();
    chk("R6", "wr1 result", mem[8'hC1], 8'h15);
    chk("R1", "wr2 untouched", mem[8'hC2], 8'h03);
    chk("R6", "reg 01 distinct", mem[8'h01], 8'h21);
    chk("R6", "rr length", d_len, 4);

    setreg(8'hC1, 8'h12);
    put(8'h03); put(8'h12); run();
    chk("R7", "indirect working", mem[8'hC1], 8'h1C);
    chk("R7", "ri length", d_len, 4);

    put(8'h04); put(8'h02); put(8'h01); run();
    chk("R8", "reg reg", mem[8'h01], 8'h24);
    chk("R8", "gg length", d_len, 6);

    setreg(8'h01, 8'h21);
    put(8'h05); put(8'h02); put(8'h01); run();
    chk("R8", "reg indirect", mem[8'h01], 8'h2B);
    chk("R1", "pointer untouched", mem[8'h02], 8'h03);

    setreg(8'h01, 8'h21);
    put(8'h06); put(8'h01); put(8'h25); run();
    chk("R9", "immediate", mem[8'h01], 8'h46);
    chk("R9", "im length", d_len, 6);

    setreg(8'h10, 8'hFF);
    put(8'h06); put(8'h10); put(8'h01); run();
    chk("R2", "FF+01 flags czsvdh", fl, 6'b110001);
    setreg(8'h11, 8'h7F);
    put(8'h06); put(8'h11); put(8'h01); run();
    chk("R4", "7F+01 flags czsvdh", fl, 6'b001101);
    setreg(8'h12, 8'h80);
    put(8'h06); put(8'h12); put(8'h80); run();
    chk("R4", "80+80 flags czsvdh", fl, 6'b110100);

    ill_seen = 0;
    put(8'h07); put(8'h00); put(8'hFF); run();
    chk("R12", "illegal pulses", ill_seen, 3);
    chk("R12", "flags kept", fl, 6'b110100);

    setreg(8'h20, 8'h05); setreg(8'h21, 8'h09);
    gap(); put(8'h04); gap(); gap(); put(8'h20); gap(); put(8'h21); run();
    chk("R11", "stalled result", mem[8'h21], 8'h0E);
    chk("R11", "stalled length", d_len, 9);
    put(8'h02); gap(); put(8'h12); run();
    chk("R11", "short stalled length", d_len, 5);

    setreg(8'h30, 8'h00);
    put(8'h06); put(8'h30); put(8'h01);
    put(8'h06); put(8'h30); put(8'h01);
    put(8'h06); put(8'h30); put(8'h01); run();
    chk("R1", "back to back", mem[8'h30], 8'h03);

    for (int blk = 0; blk < 8; blk++) begin
      rp = 8'($urandom_range(0, 255));
      for (int k = 0; k < 10; k++) begin
        int op;
        op = $urandom_range(0, 11);
        if (op < 2 || op > 6) op = (op < 2) ? op : $urandom_range(7, 255);
        if ($urandom_range(0, 3) == 0) gap();
        put(8'(op));
        if (op >= 2 && op <= 6) begin
          for (int j = 0; j < ((op <= 3) ? 1 : 2); j++) begin
            if ($urandom_range(0, 4) == 0) gap();
            put(8'($urandom_range(0, 255)));
          end
        end
      end
      run();
    end

    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== mref[i]) bad++;
      chk("R1", "register file mismatches", bad, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule